// File: doc/BRIEF.md
# Non-volatile memory command controller

This block is the software-facing control register and launch sequencer for a self-timed program/erase engine. Software writes one 16-bit control word carrying an operation code, an erase/program select, a write enable, a sequence-error flag and a go bit. When the go bit is written to 1 and the request is well formed, the block issues a one-cycle start strobe and a 2-bit operation type to the memory back end. It then holds the go bit at 1 until the back end returns a done pulse or signals termination.

The go bit is set-only from software and cleared only by hardware. An ill-formed start attempt does not reach the back end and raises the error flag. Two resets are provided: a power-on reset that clears every bit, and an ordinary system reset that clears only the operation code and the erase select.

Top module: `nvm_cmd_ctrl`

## Requirements
- R1: Readback layout: bit 15 go, bit 14 write enable, bit 13 error flag, bit 6 erase select, bits 3:0 operation code; bits 12:7 and 5:4 read 0. After power-on reset the word reads 0x0000.
- R2: A proper start attempt sets go, which reads 1 in the cycle after the write. The same cycle carries a single-cycle `be_start` with `be_op` encoded 00 word program, 01 row program, 10 page erase, 11 bulk erase.
- R3: Decode (code, select): (1111,1) bulk erase, (0010,1) page erase, (0011,0) word program, (0001,0) row program. Every other pair is a no-op.
- R4: A start attempt whose written write-enable bit is 0 sets the error flag, leaves go at 0 and issues no strobe.
- R5: A start attempt whose code/select pair is a no-op sets the error flag, leaves go at 0 and issues no strobe.
- R6: A start attempt while the stored error flag is 1 keeps the flag at 1 and issues no strobe.
- R7: A start attempt while `be_busy` is high is improper: it sets the error flag and issues no strobe.
- R8: A `be_done` pulse while go is 1 clears go and the error flag in the next cycle. A `be_done` while go is 0 has no effect.
- R9: A `be_abort` while go is 1, with no `be_done`, clears go and sets the error flag.
- R10: While go is 1, every register write is ignored and `be_op` stays stable.
- R11: Software cannot clear go. With go at 0, a write whose go bit is 0 loads write enable, error flag, select and code from the data.
- R12: `sys_rst_n` clears only select and code. Go, write enable and the error flag keep their values and are cleared only by `por_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | System reset for select and code, active low, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | REG_W | Register write data |
| rd_data | output | REG_W | Register readback |
| be_busy | input | 1 | Back end still occupied |
| be_done | input | 1 | Back end finished the operation (one cycle) |
| be_abort | input | 1 | Back end terminated the operation |
| be_start | output | 1 | One-cycle launch strobe |
| be_op | output | 2 | Operation type, valid with the strobe and held while go is 1 |

## Verification
The bench builds the block with REG_W at 16 and RD_PIPE at 0. With these values the readback is combinational, so every field change can be compared one cycle after the write that caused it. Directed sequences step through each decode pair, each kind of improper start, done and termination, and both resets. A long random run then interleaves writes with back-end done, abort and busy events at random distances from each launch. This reaches corner cases such as a write landing in the done cycle, or a done pulse arriving while idle.

// File: rtl/nvm_cmd_pkg.sv
package nvm_cmd_pkg;

   localparam int CTL_W    = 16;
   localparam int CODE_W   = 4;
   localparam int B_GO     = 15;
   localparam int B_WEN    = 14;
   localparam int B_ERR    = 13;
   localparam int B_SEL    = 6;
   localparam int CODE_LSB = 0;

   typedef enum logic [1:0] {
      OP_WORD = 2'b00,
      OP_ROW  = 2'b01,
      OP_PAGE = 2'b10,
      OP_BULK = 2'b11
   } nvm_op_e;

   localparam logic [CODE_W-1:0] C_BULK = 4'b1111;
   localparam logic [CODE_W-1:0] C_PAGE = 4'b0010;
   localparam logic [CODE_W-1:0] C_WORD = 4'b0011;
   localparam logic [CODE_W-1:0] C_ROW  = 4'b0001;

endpackage

// File: rtl/nvm_op_decode.sv
module nvm_op_decode
   import nvm_cmd_pkg::*;
(
   input  logic [CODE_W-1:0] code,
   input  logic              sel_erase,
   output logic              valid,
   output nvm_op_e           op
);

   // R3: select bit picks whether a code is real or a no-op
   always_comb begin
      valid = 1'b0;
      op    = OP_WORD;
      unique case (code)
         C_BULK: begin valid = sel_erase;  op = OP_BULK; end
         C_PAGE: begin valid = sel_erase;  op = OP_PAGE; end
         C_WORD: begin valid = !sel_erase; op = OP_WORD; end
         C_ROW:  begin valid = !sel_erase; op = OP_ROW;  end
         default: begin valid = 1'b0; op = OP_WORD; end
      endcase
   end

endmodule

// File: rtl/nvm_cmd_seq.sv
module nvm_cmd_seq
   import nvm_cmd_pkg::*;
(
   input  logic    clk,
   input  logic    por_n,
   input  logic    attempt,
   input  logic    wen_new,
   input  logic    dec_valid,
   input  nvm_op_e dec_op,
   input  logic    err_q,
   input  logic    be_busy,
   input  logic    be_done,
   input  logic    be_abort,
   output logic    go_q,
   output logic    improper,
   output logic    launch,
   output logic    done_evt,
   output logic    abort_evt,
   output logic    be_start,
   output nvm_op_e be_op
);

   // R4 R5 R6 R7: any of these makes the attempt improper
   assign improper  = attempt & (!wen_new | !dec_valid | err_q | be_busy);
   assign launch    = attempt & !improper;
   assign done_evt  = go_q & be_done;
   assign abort_evt = go_q & !be_done & be_abort;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         go_q     <= 1'b0;
         be_start <= 1'b0;
         be_op    <= OP_WORD;
      end else begin
         be_start <= launch;
         if (launch)
            be_op <= dec_op;
         if (go_q) begin
            if (done_evt || abort_evt)
               go_q <= 1'b0;
         end else if (launch) begin
            go_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/nvm_cmd_regs.sv
module nvm_cmd_regs
   import nvm_cmd_pkg::*;
#(
   parameter int REG_W = 16
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              sys_rst_n,
   input  logic              wr_acc,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              attempt,
   input  logic              improper,
   input  logic              done_evt,
   input  logic              abort_evt,
   output logic              wen_q,
   output logic              err_q,
   output logic              sel_q,
   output logic [CODE_W-1:0] code_q
);

   logic fld_rst_n;
   assign fld_rst_n = por_n & sys_rst_n;

   // R12: power-on-only bits
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         wen_q <= 1'b0;
         err_q <= 1'b0;
      end else if (wr_acc) begin
         wen_q <= wr_data[B_WEN];
         err_q <= attempt ? improper : wr_data[B_ERR];
      end else if (done_evt) begin
         err_q <= 1'b0;
      end else if (abort_evt) begin
         err_q <= 1'b1;
      end
   end

   // R12: fields cleared by either reset
   always_ff @(posedge clk or negedge fld_rst_n) begin
      if (!fld_rst_n) begin
         sel_q  <= 1'b0;
         code_q <= '0;
      end else if (wr_acc) begin
         sel_q  <= wr_data[B_SEL];
         code_q <= wr_data[CODE_LSB +: CODE_W];
      end
   end

endmodule

// File: rtl/nvm_cmd_rdback.sv
module nvm_cmd_rdback
   import nvm_cmd_pkg::*;
#(
   parameter int REG_W   = 16,
   parameter bit RD_PIPE = 1'b0
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              go_q,
   input  logic              wen_q,
   input  logic              err_q,
   input  logic              sel_q,
   input  logic [CODE_W-1:0] code_q,
   output logic [REG_W-1:0]  rd_data
);

   logic [REG_W-1:0] word;

   always_comb begin
      word                        = '0;
      word[B_GO]                  = go_q;
      word[B_WEN]                 = wen_q;
      word[B_ERR]                 = err_q;
      word[B_SEL]                 = sel_q;
      word[CODE_LSB +: CODE_W]    = code_q;
   end

   generate
      if (RD_PIPE) begin : g_pipe
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) rd_data <= '0;
            else        rd_data <= word;
         end
      end else begin : g_comb
         assign rd_data = word;
      end
   endgenerate

endmodule

// File: rtl/nvm_cmd_ctrl.sv
module nvm_cmd_ctrl
   import nvm_cmd_pkg::*;
#(
   parameter int REG_W   = 16,
   parameter bit RD_PIPE = 1'b0
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             sys_rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   input  logic             be_busy,
   input  logic             be_done,
   input  logic             be_abort,
   output logic             be_start,
   output logic [1:0]       be_op
);

   generate
      if (REG_W < CTL_W) begin : g_bad_width
         $error("nvm_cmd_ctrl: REG_W must be at least 16");
      end
   endgenerate

   logic              go_q, wen_q, err_q, sel_q;
   logic [CODE_W-1:0] code_q;
   logic              wr_acc, attempt, improper, launch;
   logic              done_evt, abort_evt, dec_valid;
   nvm_op_e           dec_op, op_q;

   // R10 R11: writes taken only when idle
   assign wr_acc  = wr_en & !go_q;
   assign attempt = wr_acc & wr_data[B_GO];

   nvm_op_decode u_dec (
      .code      (wr_data[CODE_LSB +: CODE_W]),
      .sel_erase (wr_data[B_SEL]),
      .valid     (dec_valid),
      .op        (dec_op)
   );

   nvm_cmd_seq u_seq (
      .clk       (clk),
      .por_n     (por_n),
      .attempt   (attempt),
      .wen_new   (wr_data[B_WEN]),
      .dec_valid (dec_valid),
      .dec_op    (dec_op),
      .err_q     (err_q),
      .be_busy   (be_busy),
      .be_done   (be_done),
      .be_abort  (be_abort),
      .go_q      (go_q),
      .improper  (improper),
      .launch    (launch),
      .done_evt  (done_evt),
      .abort_evt (abort_evt),
      .be_start  (be_start),
      .be_op     (op_q)
   );

   assign be_op = op_q;

   nvm_cmd_regs #(.REG_W(REG_W)) u_regs (
      .clk       (clk),
      .por_n     (por_n),
      .sys_rst_n (sys_rst_n),
      .wr_acc    (wr_acc),
      .wr_data   (wr_data),
      .attempt   (attempt),
      .improper  (improper),
      .done_evt  (done_evt),
      .abort_evt (abort_evt),
      .wen_q     (wen_q),
      .err_q     (err_q),
      .sel_q     (sel_q),
      .code_q    (code_q)
   );

   nvm_cmd_rdback #(.REG_W(REG_W), .RD_PIPE(RD_PIPE)) u_rd (
      .clk     (clk),
      .por_n   (por_n),
      .go_q    (go_q),
      .wen_q   (wen_q),
      .err_q   (err_q),
      .sel_q   (sel_q),
      .code_q  (code_q),
      .rd_data (rd_data)
   );

endmodule

// File: rtl/nvm_cmd_chk.sv
module nvm_cmd_chk #(
   parameter int REG_W = 16
) (
   input logic             clk,
   input logic             por_n,
   input logic             wr_en,
   input logic [REG_W-1:0] wr_data,
   input logic             be_busy,
   input logic             be_done,
   input logic             be_abort,
   input logic             be_start,
   input logic [1:0]       be_op,
   input logic             go,
   input logic             err
);

   p_strobe_single_r2: assert property (@(posedge clk) disable iff (!por_n)
      be_start |=> !be_start);

   p_strobe_with_go_r2: assert property (@(posedge clk) disable iff (!por_n)
      be_start |-> go);

   p_op_held_r10: assert property (@(posedge clk) disable iff (!por_n)
      (go && $past(go)) |-> $stable(be_op));

   p_done_clears_r8: assert property (@(posedge clk) disable iff (!por_n)
      (go && be_done) |=> (!go && !err));

   p_abort_flags_r9: assert property (@(posedge clk) disable iff (!por_n)
      (go && !be_done && be_abort) |=> (!go && err));

   p_no_sw_clear_r11: assert property (@(posedge clk) disable iff (!por_n)
      (go && !be_done && !be_abort) |=> go);

   p_wen_low_blocks_r4: assert property (@(posedge clk) disable iff (!por_n)
      (!go && wr_en && wr_data[15] && !wr_data[14]) |=> (!be_start && err && !go));

   p_err_blocks_r6: assert property (@(posedge clk) disable iff (!por_n)
      (!go && err && wr_en && wr_data[15]) |=> (!be_start && err));

   p_busy_blocks_r7: assert property (@(posedge clk) disable iff (!por_n)
      (!go && be_busy && wr_en && wr_data[15]) |=> (!be_start && err));

endmodule

bind nvm_cmd_ctrl nvm_cmd_chk #(.REG_W(REG_W)) u_chk (
   .clk      (clk),
   .por_n    (por_n),
   .wr_en    (wr_en),
   .wr_data  (wr_data),
   .be_busy  (be_busy),
   .be_done  (be_done),
   .be_abort (be_abort),
   .be_start (be_start),
   .be_op    (be_op),
   .go       (go_q),
   .err      (err_q)
);

// File: tb/nvm_cmd_ctrl_test.sv
`timescale 1ns/1ps
module nvm_cmd_ctrl_test;

   logic        clk = 1'b0;
   logic        por_n = 1'b0, sys_rst_n = 1'b1;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        be_busy = 1'b0, be_done = 1'b0, be_abort = 1'b0;
   logic        be_start;
   logic [1:0]  be_op;

   always #2.5 clk = ~clk;

   nvm_cmd_ctrl uut (
      .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
      .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .be_busy(be_busy), .be_done(be_done), .be_abort(be_abort),
      .be_start(be_start), .be_op(be_op)
   );

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   // expected state
   logic       m_go = 0, m_wen = 0, m_err = 0, m_sel = 0, m_bs = 0;
   logic [3:0] m_code = 0;
   logic [1:0] m_op = 0;
   string      cur_tag = "R1";
   int         countdown = -1;

   function automatic logic [2:0] dec(input logic [3:0] c, input logic s);
      case (c)
         4'hF: return {s, 2'b11};
         4'h2: return {s, 2'b10};
         4'h3: return {!s, 2'b00};
         4'h1: return {!s, 2'b01};
         default: return 3'b000;
      endcase
   endfunction

   function automatic logic [15:0] exp_rd();
      return {m_go, m_wen, m_err, 6'b0, m_sel, 2'b0, m_code};
   endfunction

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(input logic wr, input logic [15:0] d, input logic dn,
                       input logic ab, input logic bz, input logic sy, input string tg);
      logic [2:0] dv;
      logic       bad;
      @(negedge clk);
      check({cur_tag, " readback"}, rd_data, exp_rd());
      check({cur_tag, " strobe"}, {15'b0, be_start}, {15'b0, m_bs});
      if (m_bs) check({cur_tag, " op"}, {14'b0, be_op}, {14'b0, m_op});
      wr_en = wr; wr_data = d; be_done = dn; be_abort = ab; be_busy = bz; sys_rst_n = sy;
      m_bs = 0;
      if (m_go) begin
         if (dn) begin m_go = 0; m_err = 0; end
         else if (ab) begin m_go = 0; m_err = 1; end
      end else if (wr) begin
         m_wen = d[14]; m_sel = d[6]; m_code = d[3:0];
         if (d[15]) begin
            dv  = dec(d[3:0], d[6]);
            bad = !d[14] || !dv[2] || m_err || bz;
            m_err = bad;
            if (!bad) begin m_go = 1; m_bs = 1; m_op = dv[1:0]; end
         end else begin
            m_err = d[13];
         end
      end
      if (!sy) begin m_sel = 0; m_code = 0; end
      cur_tag = tg;
   endtask

   task automatic idle(input string tg);
      step(0, 16'h0, 0, 0, 0, 1, tg);
   endtask

   task automatic wr(input logic [15:0] d, input string tg);
      step(1, d, 0, 0, 0, 1, tg);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      idle("R1");                      // reset value
      wr(16'h7FFF, "R1");              // layout, unimplemented bits drop
      wr(16'h0000, "R11");             // software clears error flag
      wr(16'hC003, "R3");              // word program
      wr(16'h0000, "R10");             // ignored while in progress
      wr(16'h4000, "R11");             // cannot clear go
      step(0, 0, 1, 0, 0, 1, "R8");    // done
      step(0, 0, 1, 0, 0, 1, "R8");    // done while idle ignored
      wr(16'hC04F, "R2");              // bulk erase
      idle("R2");
      step(0, 0, 0, 1, 0, 1, "R9");    // termination
      wr(16'hC04F, "R6");              // error flag set blocks start
      wr(16'h4000, "R11");
      wr(16'h8003, "R4");              // write enable low
      wr(16'h4000, "R11");
      wr(16'hC043, "R5");              // erase select with program code
      wr(16'h4000, "R11");
      wr(16'hC00F, "R5");              // bulk code without erase select
      wr(16'h4000, "R11");
      wr(16'hC045, "R5");              // unimplemented code
      wr(16'h4000, "R11");
      step(1, 16'hC001, 0, 0, 1, 1, "R7"); // back end busy
      wr(16'h4000, "R11");
      wr(16'hC042, "R3");              // page erase
      step(0, 0, 1, 0, 0, 1, "R8");
      wr(16'hC001, "R3");              // row program
      step(0, 0, 1, 0, 0, 1, "R8");
      wr(16'h604F, "R12");
      step(0, 0, 0, 0, 0, 0, "R12");   // system reset
      idle("R12");

      // random phase
      for (int i = 0; i < 4000; i++) begin
         logic [15:0] d;
         logic        w, dn, ab, bz;
         logic [3:0]  codes [5];
         codes[0] = 4'hF; codes[1] = 4'h2; codes[2] = 4'h3; codes[3] = 4'h1;
         codes[4] = 4'($urandom);
         d       = 16'($urandom);
         d[3:0]  = codes[$urandom_range(0, 4)];
         d[14]   = ($urandom_range(0, 7) != 0);
         d[13]   = ($urandom_range(0, 5) == 0);
         w  = ($urandom_range(0, 2) == 0);
         bz = ($urandom_range(0, 9) == 0);
         dn = 0; ab = 0;
         if (m_go) begin
            if (countdown < 0) countdown = $urandom_range(0, 5);
            if (countdown == 0) begin
               if ($urandom_range(0, 4) == 0) ab = 1; else dn = 1;
               countdown = -1;
            end else countdown--;
         end else begin
            dn = ($urandom_range(0, 15) == 0);
            ab = ($urandom_range(0, 15) == 0);
         end
         step(w, d, dn, ab, bz, 1, "R3");
      end
      idle("R2");
      idle("R1");

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule